// File: doc/BRIEF.md
# Oversampled Serial Receiver with Long-Break Detection

This block receives asynchronous serial characters from a single data line that is sampled at sixteen times the bit rate. A character is a low start bit, eight or nine data bits sent least significant bit first, and a high stop bit. Each bit is decided by a majority vote of three samples taken near its centre. A completed character goes to a holding register. A data-full flag stays set until a clear strobe, which stands in for a software read of the data register.

A run monitor watches how long the line stays at one level. A long enough low run is reported as a break. A high run of one character length marks the line as idle and ends the receiver-active status. A long-break mode raises the break threshold by one bit time, so that a zero character stretched by clock mismatch between nodes is not taken for a LIN break. While this mode is on, no character is posted, so neither data-full nor framing error can set. An inversion control flips the line before any other logic sees it.

The surrounding logic supplies the sample tick, the mode controls and the clear strobe. It reads the data byte, the ninth bit and the flags.

Top module: `lin_uart_rx`

## Requirements
- R1: In 8-bit mode (`nine_bit`=0) a frame is start bit, 8 data bits least significant first, stop bit. When the stop bit has been sampled, `rx_byte` holds the data, `rx_bit9` is 0 and `data_full` is 1.
- R2: In 9-bit mode (`nine_bit`=1) the ninth received bit is loaded into `rx_bit9` in the same cycle as `rx_byte`. Both stay unchanged until `clr_strobe` releases the holding register.
- R3: A falling edge starts a frame only if at least two of the samples at ticks 7, 8 and 9 after the edge read low. Otherwise the receiver returns to waiting for a start bit, and `rx_active` and `data_full` are unaffected.
- R4: `rx_active` rises after a start bit is validated. It falls once the line has been high for one character time: 160 ticks in 8-bit mode, 176 in 9-bit mode.
- R5: With `long_brk`=0, a stop bit sampled low sets `frame_err` together with `data_full`, and the data is still loaded.
- R6: A character that completes while `data_full` is 1 sets `overrun` and leaves `rx_byte` and `rx_bit9` unchanged.
- R7: A one-cycle `clr_strobe` clears `data_full`, `frame_err`, `overrun` and `brk_det`.
- R8: With `long_brk`=0, `brk_det` sets after 10 consecutive low bit times (160 ticks) in 8-bit mode and after 11 (176 ticks) in 9-bit mode.
- R9: With `long_brk`=1 the break threshold is 11 bit times (176 ticks) in 8-bit mode and 12 (192 ticks) in 9-bit mode. A zero character stretched to 10.5 bit times is therefore not a break.
- R10: While `long_brk`=1, completed characters are not posted: `data_full` and `frame_err` do not set.
- R11: With `inv_en`=1 the line is inverted before all processing, so data, start, stop, break and idle all work on the inverted level.
- R12: After a break, the receiver searches for no new start bit until the line has been seen high. A low level that continues past the break produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial data line, idle high before inversion |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| long_brk | input | 1 | Long-break mode: threshold plus one bit, no posting |
| inv_en | input | 1 | Invert the incoming line |
| clr_strobe | input | 1 | Models a data-register read; clears the flags |
| rx_byte | output | 8 | Buffered data byte |
| rx_bit9 | output | 1 | Buffered ninth data bit (0 in 8-bit mode) |
| data_full | output | 1 | Holding register contains an unread character |
| frame_err | output | 1 | Last posted character had a low stop bit |
| overrun | output | 1 | A character was dropped because the register was full |
| brk_det | output | 1 | Break seen on the line |
| rx_active | output | 1 | Receiver is inside a character and the line has not gone idle |

## Verification
The bench drives low runs just under and just over every break threshold in all four combinations of data length and long-break mode. A design that ignored the mode or the ninth bit would report a break half a bit too early or too late. Stretched zero characters in long-break mode show that data-full and framing error stay low, and a design that still posted such characters would raise them. A low level held well past a break exposes a receiver that restarts immediately: it would build a second zero character with a framing error. A short low glitch, two back-to-back characters without a clear, and a measured high run around the idle length cover false starts, a holding register that gets overwritten, and an active flag that drops early or late.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_e;

  // Majority of three line samples.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Bit times in one whole character: start, data, stop.
  function automatic int unsigned char_bits(input logic nine);
    return nine ? 11 : 10;
  endfunction

  // Consecutive low bit times that make up a break.
  function automatic int unsigned brk_bits(input logic nine, input logic lng);
    return char_bits(nine) + (lng ? 1 : 0);
  endfunction

endpackage

// File: rtl/lin_rx_front.sv
module lin_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic inv_en,
  output logic line
);
  logic [SYNC_STAGES-1:0] sync_q;

  // Inversion sits ahead of the synchroniser, so every later stage sees the
  // corrected level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd ^ inv_en};
  end

  assign line = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/lin_rx_levelmon.sv
module lin_rx_levelmon
  import lin_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic nine_bit,
  input  logic long_brk,
  output logic brk_evt,
  output logic idle_evt
);
  localparam int CW = $clog2(13 * OVS + 1);

  logic [CW-1:0] low_run, high_run, brk_lim, idle_lim;

  assign brk_lim  = CW'(brk_bits(nine_bit, long_brk) * OVS);
  assign idle_lim = CW'(char_bits(nine_bit) * OVS);

  // Each event fires once, on the tick that brings a run to its limit.
  assign brk_evt  = tick && !line && (low_run  == brk_lim  - 1'b1);
  assign idle_evt = tick &&  line && (high_run == idle_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else if (tick) begin
      if (line) begin
        low_run <= '0;
        if (high_run != '1) high_run <= high_run + 1'b1;
      end else begin
        high_run <= '0;
        if (low_run != '1) low_run <= low_run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_rx_frame.sv
module lin_rx_frame
  import lin_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line,
  input  logic      nine_bit,
  input  logic      abort,
  output logic      start_ok,
  output logic      char_done,
  output logic      stop_ok,
  output logic [8:0] shreg,
  output rx_state_e state_o
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] V0   = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] V1   = SW'(OVS / 2);
  localparam logic [SW-1:0] V2   = SW'(OVS / 2 + 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);

  rx_state_e     state;
  logic [SW-1:0] smp;
  logic [3:0]    bit_idx;
  logic [1:0]    votes;
  logic          vote_now, bit_val;
  logic [3:0]    last_idx;

  assign last_idx  = nine_bit ? 4'd8 : 4'd7;
  assign vote_now  = tick && (smp == V2) &&
                     (state == ST_START || state == ST_DATA || state == ST_STOP);
  assign bit_val   = maj3(votes[0], votes[1], line);
  assign start_ok  = vote_now && (state == ST_START) && !bit_val && !abort;
  assign char_done = vote_now && (state == ST_STOP) && !abort;
  assign stop_ok   = bit_val;
  assign state_o   = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      smp     <= '0;
      bit_idx <= '0;
      votes   <= '0;
      shreg   <= '0;
    end else if (abort) begin
      state <= ST_WAIT_HIGH;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!line) begin
            state <= ST_START;
            smp   <= SW'(1);
          end
        end
        ST_WAIT_HIGH: begin
          if (line) state <= ST_IDLE;
        end
        default: begin
          smp <= (smp == LAST) ? '0 : smp + 1'b1;
          if (smp == V0) votes[0] <= line;
          if (smp == V1) votes[1] <= line;
          if (smp == V2) begin
            case (state)
              ST_START: begin
                if (bit_val) state <= ST_IDLE;
                else begin
                  bit_idx <= '0;
                  shreg   <= '0;
                end
              end
              ST_DATA: shreg[bit_idx] <= bit_val;
              default: state <= ST_IDLE;
            endcase
          end
          if (smp == LAST) begin
            if (state == ST_START) state <= ST_DATA;
            else if (state == ST_DATA) begin
              if (bit_idx == last_idx) state <= ST_STOP;
              else bit_idx <= bit_idx + 4'd1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
  import lin_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic       nine_bit,
  input  logic       long_brk,
  input  logic       inv_en,
  input  logic       clr_strobe,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       data_full,
  output logic       frame_err,
  output logic       overrun,
  output logic       brk_det,
  output logic       rx_active
);
  logic       line, brk_evt, idle_evt, start_ok, char_done, stop_ok;
  logic [8:0] shreg;
  rx_state_e  frame_state;

  lin_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .inv_en(inv_en), .line(line)
  );

  lin_rx_levelmon #(.OVS(OVS)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line),
    .nine_bit(nine_bit), .long_brk(long_brk),
    .brk_evt(brk_evt), .idle_evt(idle_evt)
  );

  lin_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line),
    .nine_bit(nine_bit), .abort(brk_evt),
    .start_ok(start_ok), .char_done(char_done), .stop_ok(stop_ok),
    .shreg(shreg), .state_o(frame_state)
  );

  // Holding register and flags; a new setting wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_bit9   <= 1'b0;
      data_full <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      brk_det   <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      if (clr_strobe) begin
        data_full <= 1'b0;
        frame_err <= 1'b0;
        overrun   <= 1'b0;
        brk_det   <= 1'b0;
      end
      if (char_done && !long_brk) begin
        if (data_full) overrun <= 1'b1;
        else begin
          rx_byte   <= shreg[7:0];
          rx_bit9   <= nine_bit & shreg[8];
          data_full <= 1'b1;
          frame_err <= !stop_ok;
        end
      end
      if (brk_evt) brk_det <= 1'b1;
      if (start_ok)      rx_active <= 1'b1;
      else if (idle_evt) rx_active <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_uart_rx_chk.sv
module lin_uart_rx_chk
  import lin_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       long_brk,
  input logic       clr_strobe,
  input logic [7:0] rx_byte,
  input logic       rx_bit9,
  input logic       data_full,
  input logic       frame_err,
  input logic       overrun,
  input logic       brk_det,
  input logic       rx_active,
  input logic       line,
  input logic       brk_evt,
  input logic       idle_evt,
  input logic       start_ok,
  input logic       char_done,
  input rx_state_e  frame_state
);
  assert_active_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> rx_active);

  assert_active_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !start_ok) |=> !rx_active);

  assert_overrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !long_brk && data_full) |=> (overrun && $stable(rx_byte) && $stable(rx_bit9)));

  assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !char_done && !brk_evt) |=> (!data_full && !frame_err && !overrun && !brk_det));

  assert_brk_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !line);

  assert_brk_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_det);

  assert_no_post_long_R10: assert property (@(posedge clk) disable iff (!rst_n)
    long_brk |=> (!$rose(data_full) && !$rose(frame_err)));

  assert_wait_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (frame_state == ST_WAIT_HIGH));
endmodule

bind lin_uart_rx lin_uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .long_brk(long_brk), .clr_strobe(clr_strobe),
  .rx_byte(rx_byte), .rx_bit9(rx_bit9), .data_full(data_full),
  .frame_err(frame_err), .overrun(overrun), .brk_det(brk_det),
  .rx_active(rx_active), .line(line), .brk_evt(brk_evt), .idle_evt(idle_evt),
  .start_ok(start_ok), .char_done(char_done), .frame_state(frame_state)
);

// File: tb/lin_uart_rx_tb.sv
module lin_uart_rx_tb;
  localparam int BIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0;
  logic       long_brk = 1'b0;
  logic       inv_en = 1'b0;
  logic       clr_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9, data_full, frame_err, overrun, brk_det, rx_active;

  int checks = 0;
  int failures = 0;

  lin_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .nine_bit(nine_bit), .long_brk(long_brk), .inv_en(inv_en),
    .clr_strobe(clr_strobe), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .data_full(data_full), .frame_err(frame_err), .overrun(overrun),
    .brk_det(brk_det), .rx_active(rx_active)
  );

  always #10 clk = ~clk;

  // Sample tick: one clock high out of every four, changed at the falling edge.
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % 4;
      sample_tick = (tcnt == 3);
    end
  end

  // Vector fields: {nine_bit, inv_en, data[8:0]}.
  localparam logic [10:0] VECS [6] = '{
    {1'b0, 1'b0, 9'h0A5},
    {1'b0, 1'b0, 9'h13C},
    {1'b0, 1'b1, 9'h0F0},
    {1'b1, 1'b0, 9'h1C3},
    {1'b1, 1'b1, 9'h100},
    {1'b1, 1'b0, 9'h0FF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sync_tick();
    @(posedge clk);
    while (!sample_tick) @(posedge clk);
  endtask

  // Hold a logical level for n ticks; the task returns on the last tick edge.
  task automatic drive(input logic lvl, input int n);
    @(negedge clk);
    rxd = lvl ^ inv_en;
    for (int i = 0; i < n; i++) sync_tick();
  endtask

  task automatic send_char(input logic [8:0] d, input logic stop_lvl);
    drive(1'b0, BIT);
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) drive(d[i], BIT);
    drive(stop_lvl, BIT);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_strobe = 1'b1;
    @(negedge clk) clr_strobe = 1'b0;
    sync_tick();
  endtask

  task automatic set_mode(input logic nb, input logic lb, input logic inv);
    @(negedge clk);
    nine_bit = nb;
    long_brk = lb;
    inv_en   = inv;
    rxd      = ~inv;
    drive(1'b1, 2 * BIT);
  endtask

  // Low run of n ticks, then back to idle; check the break and posting flags.
  task automatic brk_case(input string req, input int n, input logic exp_brk,
                          input logic chk_post, input logic exp_full, input logic exp_fe);
    drive(1'b0, n);
    drive(1'b1, 13 * BIT);
    @(negedge clk);
    chk({req, " brk_det"}, 16'(brk_det), 16'(exp_brk));
    if (chk_post) begin
      chk({req, " data_full"}, 16'(data_full), 16'(exp_full));
      chk({req, " frame_err"}, 16'(frame_err), 16'(exp_fe));
    end
    pulse_clr();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // Reset state
    chk("reset rx_byte", 16'(rx_byte), 16'h0);
    chk("reset data_full", 16'(data_full), 16'h0);
    chk("reset flags", 16'({frame_err, overrun, brk_det, rx_active, rx_bit9}), 16'h0);
    rst_n = 1'b1;
    sync_tick();
    drive(1'b1, 12 * BIT);

    // Table of characters: R1 8-bit, R2 9-bit, R11 inverted line
    for (int v = 0; v < 6; v++) begin
      logic [8:0] d;
      logic nb;
      nb = VECS[v][10];
      d  = VECS[v][8:0];
      set_mode(nb, 1'b0, VECS[v][9]);
      send_char(d, 1'b1);
      @(negedge clk);
      chk(VECS[v][9] ? "R11 rx_byte" : (nb ? "R2 rx_byte" : "R1 rx_byte"),
          16'(rx_byte), 16'(d[7:0]));
      chk(nb ? "R2 rx_bit9" : "R1 rx_bit9", 16'(rx_bit9), 16'(nb & d[8]));
      chk("R1 data_full", 16'(data_full), 16'h1);
      chk("R5 frame_err on good stop", 16'(frame_err), 16'h0);
      pulse_clr();
      chk("R7 data_full cleared", 16'(data_full), 16'h0);
    end

    // R4: active during the character, low after one character time of high
    set_mode(1'b0, 1'b0, 1'b0);
    drive(1'b1, 12 * BIT);
    send_char(9'h055, 1'b1);
    @(negedge clk);
    chk("R4 active after character", 16'(rx_active), 16'h1);
    sync_tick();
    drive(1'b1, 100);
    @(negedge clk);
    chk("R4 active before idle time", 16'(rx_active), 16'h1);
    sync_tick();
    drive(1'b1, 60);
    @(negedge clk);
    chk("R4 inactive after idle time", 16'(rx_active), 16'h0);
    pulse_clr();

    // R3: short low glitch is not a start bit
    drive(1'b0, 4);
    drive(1'b1, 40);
    @(negedge clk);
    chk("R3 glitch rx_active", 16'(rx_active), 16'h0);
    chk("R3 glitch data_full", 16'(data_full), 16'h0);

    // R5: low stop bit
    send_char(9'h03C, 1'b0);
    drive(1'b1, 2 * BIT);
    @(negedge clk);
    chk("R5 frame_err", 16'(frame_err), 16'h1);
    chk("R5 data_full", 16'(data_full), 16'h1);
    chk("R5 rx_byte", 16'(rx_byte), 16'h3C);
    pulse_clr();
    chk("R7 frame_err cleared", 16'(frame_err), 16'h0);

    // R6 with R2: second character while full, ninth bit held
    set_mode(1'b1, 1'b0, 1'b0);
    send_char(9'h1A5, 1'b1);
    send_char(9'h03C, 1'b1);
    drive(1'b1, 2 * BIT);
    @(negedge clk);
    chk("R6 overrun", 16'(overrun), 16'h1);
    chk("R6 rx_byte kept", 16'(rx_byte), 16'hA5);
    chk("R2 rx_bit9 kept", 16'(rx_bit9), 16'h1);
    pulse_clr();
    chk("R7 all flags cleared", 16'({data_full, frame_err, overrun, brk_det}), 16'h0);

    // Break thresholds
    set_mode(1'b0, 1'b0, 1'b0);
    brk_case("R8 8-bit 9 bits low", 144, 1'b0, 1'b0, 1'b0, 1'b0);
    brk_case("R8 8-bit 10.5 bits low", 168, 1'b1, 1'b1, 1'b1, 1'b1);
    set_mode(1'b0, 1'b1, 1'b0);
    brk_case("R9 R10 long 8-bit 10.5 bits", 168, 1'b0, 1'b1, 1'b0, 1'b0);
    brk_case("R9 R10 long 8-bit 11.5 bits", 184, 1'b1, 1'b1, 1'b0, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0);
    brk_case("R8 9-bit 10.5 bits low", 168, 1'b0, 1'b0, 1'b0, 1'b0);
    brk_case("R8 9-bit 11.5 bits low", 184, 1'b1, 1'b0, 1'b0, 1'b0);
    set_mode(1'b1, 1'b1, 1'b0);
    brk_case("R9 R10 long 9-bit 11.5 bits", 184, 1'b0, 1'b1, 1'b0, 1'b0);
    brk_case("R9 long 9-bit 12.5 bits", 200, 1'b1, 1'b0, 1'b0, 1'b0);
    set_mode(1'b0, 1'b0, 1'b1);
    brk_case("R11 inverted break", 168, 1'b1, 1'b0, 1'b0, 1'b0);

    // R12: low continues well past the break; no new character
    set_mode(1'b0, 1'b0, 1'b0);
    drive(1'b0, 168);
    @(negedge clk);
    chk("R12 break seen", 16'(brk_det), 16'h1);
    pulse_clr();
    drive(1'b0, 200);
    @(negedge clk);
    chk("R12 no char while low", 16'({data_full, frame_err, brk_det}), 16'h0);
    sync_tick();
    drive(1'b1, 13 * BIT);
    @(negedge clk);
    chk("R12 no char after release", 16'({data_full, frame_err, brk_det}), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule